// File: doc/BRIEF.md
# Single-IO eSPI controller byte engine

This block is the execution unit that sits between a small program sequencer and the pads of an eSPI link, on the controller side. It runs only in single-IO mode. The sequencer hands it one primitive at a time: open a frame, close a frame, send a byte, receive a byte, run a turnaround, clear the receive CRC, read the receive CRC, or set the level of the link reset line. The engine carries out the bus activity and pulses a completion strobe. A receive returns its byte, and a CRC read returns the residue.

The engine knows nothing about packets, channels or response codes. Every transmitted byte, including any trailing CRC byte, is sent exactly as the sequencer supplies it. The turnaround length is taken literally, so deliberately wrong turnarounds can be produced. The one piece of protocol help is a CRC-8 accumulator (polynomial 0x07, initial value zero). It folds in every received byte, so a program can clear it, read a packet including its trailing CRC byte, and test the residue for zero.

The serial clock is divided from the fabric clock: 100 MHz in, 20 MHz out with the defaults. It idles low. Data goes out MSB first. Outgoing bits change on the falling SCK edge, and incoming bits are sampled on the rising edge.

Top module: `espi_shift_engine`

## Requirements
- R1: After reset, espiCsN is 1, espiSck is 0, espiIo0Oe is 0, espiRstN is 0 (link reset asserted), cmdReady is 1, and the receive CRC is 0x00.
- R2: Opcode 0 (frame open) drives espiCsN low and espiIo0Oe high. Opcode 1 (frame close) drives espiCsN high and espiIo0Oe low. For both, and for opcodes 5, 6 and 7, cmdDone pulses in the cycle after acceptance.
- R3: Opcode 2 (send) emits cmdData verbatim, MSB first, as eight SCK pulses. espiIo0 is stable at every rising edge and changes only as SCK falls. A send leaves the receive CRC unchanged. cmdDone pulses after the last SCK fall.
- R4: Each SCK period lasts CLK_DIV fabric cycles: CLK_DIV-SCK_HIGH cycles low, then SCK_HIGH cycles high. SCK is low whenever no command is running. The defaults are 5 and 2, which gives 20 MHz from 100 MHz.
- R5: Opcode 3 (receive) produces eight SCK pulses and samples espiIo1 on each rising edge, MSB first. The assembled byte appears on rdData together with cmdDone.
- R6: Each received byte B updates the CRC as crc = F(crc XOR B), where F shifts left eight times and XORs 0x07 whenever the bit shifted out is 1. Opcode 6 (CRC read) returns the current value on rdData with cmdDone.
- R7: Opcode 5 (CRC clear) sets the CRC to 0x00, so bytes received earlier have no effect on later reads. After a packet and its correct trailing CRC byte are received, the residue is 0x00.
- R8: Opcode 4 (turnaround) produces exactly N SCK pulses, where N is cmdData[TAR_W-1:0]. N = 0 completes with no pulse. espiIo0Oe goes low when the turnaround is accepted and stays low until frame close, or until a new frame open.
- R9: A command presented while cmdReady is 0 is ignored. It has no effect on espiCsN, on the byte being shifted, or on cmdDone.
- R10: Opcode 7 sets espiRstN to cmdData[0]. alertSeen equals the inverse of espiAlertN, delayed through two register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 3 | Command opcode (0..7, see R2-R10) |
| cmdData | input | 8 | Byte to send, turnaround count, or reset level |
| cmdReady | output | 1 | Engine idle and able to accept a command |
| cmdDone | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Received byte or CRC residue |
| espiCsN | output | 1 | Chip select, active low |
| espiSck | output | 1 | Serial clock |
| espiIo0 | output | 1 | Outgoing data line |
| espiIo0Oe | output | 1 | Output enable for the outgoing data line |
| espiIo1 | input | 1 | Incoming data line |
| espiRstN | output | 1 | Link reset, active low |
| espiAlertN | input | 1 | Alert from the target, active low |
| alertSeen | output | 1 | Synchronised alert, active high |

## Verification
The bench builds the block with its defaults: CLK_DIV 5, SCK_HIGH 2, TAR_W 4. These give an asymmetric 3-low/2-high SCK, so a swap of the low and high phase lengths shows up in the measured high width and period. TAR_W 4 makes turnaround counts 0 to 3 reachable, covering the legal value, both violations and the empty case. A target model clocked on SCK falling edges supplies seeded random response bytes. A full packet with its computed CRC byte checks that the residue reaches zero.

// File: rtl/espi_eng_pkg.sv
package espi_eng_pkg;

  typedef enum logic [2:0] {
    OP_CS_OPEN   = 3'd0,
    OP_CS_CLOSE  = 3'd1,
    OP_SEND      = 3'd2,
    OP_RECV      = 3'd3,
    OP_TURN      = 3'd4,
    OP_CRC_CLEAR = 3'd5,
    OP_CRC_READ  = 3'd6,
    OP_LINK_RST  = 3'd7
  } engOp_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic csLow;
    logic csHigh;
    logic oeOff;
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic sckSet;
    logic sckClr;
    logic finishRx;
    logic crcClear;
    logic crcRead;
    logic setRst;
    logic done;
  } engStrobe_t;

  // one byte through the x^8+x^2+x+1 generator, MSB first
  function automatic logic [7:0] crc8Fold(input logic [7:0] acc, input logic [7:0] din);
    logic [7:0] r;
    r = acc ^ din;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/espi_eng_ctrl.sv
module espi_eng_ctrl
  import espi_eng_pkg::*;
#(
  parameter int CLK_DIV  = 5,
  parameter int SCK_HIGH = 2,
  parameter int TAR_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [7:0]       cmdData,
  output logic             cmdReady,
  output engStrobe_t       strobe
);

  localparam int SCK_LOW = CLK_DIV - SCK_HIGH;
  localparam int PH_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int CNT_W   = (TAR_W > 3) ? TAR_W : 3;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(SCK_LOW - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_BYTE, S_TURN} ctlState_t;

  ctlState_t        state;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] pulseCnt;
  logic [CNT_W-1:0] pulseLast;
  logic             isRecv;

  logic             accept;
  logic [CNT_W-1:0] turnLen;
  logic             endOfPulse;
  logic             lastPulse;

  assign cmdReady   = (state == S_IDLE);
  assign accept     = cmdValid && cmdReady;
  assign turnLen    = CNT_W'(cmdData[TAR_W-1:0]);
  assign endOfPulse = (state != S_IDLE) && (phase == PH_LAST);
  assign lastPulse  = (pulseCnt == pulseLast);

  always_comb begin
    strobe = '0;
    if (accept) begin
      unique case (engOp_t'(cmdOp))
        OP_CS_OPEN:   begin strobe.csLow = 1'b1;    strobe.done = 1'b1; end
        OP_CS_CLOSE:  begin strobe.csHigh = 1'b1;   strobe.done = 1'b1; end
        OP_SEND:      strobe.loadTx = 1'b1;
        OP_RECV:      ;
        OP_TURN:      begin
          strobe.oeOff = 1'b1;
          strobe.done  = (turnLen == '0);
        end
        OP_CRC_CLEAR: begin strobe.crcClear = 1'b1; strobe.done = 1'b1; end
        OP_CRC_READ:  begin strobe.crcRead = 1'b1;  strobe.done = 1'b1; end
        OP_LINK_RST:  begin strobe.setRst = 1'b1;   strobe.done = 1'b1; end
        default:      ;
      endcase
    end
    if (state != S_IDLE && phase == PH_RISE) begin
      strobe.sckSet   = 1'b1;
      strobe.sampleRx = (state == S_BYTE);
    end
    if (endOfPulse) begin
      strobe.sckClr = 1'b1;
      if (lastPulse) begin
        strobe.done     = 1'b1;
        strobe.finishRx = (state == S_BYTE) && isRecv;
      end else if (state == S_BYTE) begin
        strobe.shiftTx  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      phase     <= '0;
      pulseCnt  <= '0;
      pulseLast <= '0;
      isRecv    <= 1'b0;
    end else begin
      if (accept) begin
        phase    <= '0;
        pulseCnt <= '0;
        if (engOp_t'(cmdOp) == OP_SEND || engOp_t'(cmdOp) == OP_RECV) begin
          state     <= S_BYTE;
          pulseLast <= CNT_W'(7);
          isRecv    <= (engOp_t'(cmdOp) == OP_RECV);
        end else if (engOp_t'(cmdOp) == OP_TURN && turnLen != '0) begin
          state     <= S_TURN;
          pulseLast <= turnLen - CNT_W'(1);
          isRecv    <= 1'b0;
        end
      end else if (state != S_IDLE) begin
        if (endOfPulse) begin
          phase    <= '0;
          pulseCnt <= pulseCnt + CNT_W'(1);
          if (lastPulse) begin
            state <= S_IDLE;
          end
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/espi_eng_dp.sv
module espi_eng_dp
  import espi_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  engStrobe_t strobe,
  input  logic [7:0] cmdData,
  input  logic       io1In,
  input  logic       alertNIn,
  output logic       cmdDone,
  output logic [7:0] rdData,
  output logic       csN,
  output logic       sck,
  output logic       io0,
  output logic       io0Oe,
  output logic       linkRstN,
  output logic       alertSeen
);

  logic [7:0] txShift;
  logic [7:0] rxShift;
  logic [7:0] crcAcc;
  logic [1:0] alertSync;

  assign alertSeen = alertSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN       <= 1'b1;
      sck       <= 1'b0;
      io0       <= 1'b0;
      io0Oe     <= 1'b0;
      txShift   <= '0;
      rxShift   <= '0;
      crcAcc    <= '0;
      rdData    <= '0;
      cmdDone   <= 1'b0;
      linkRstN  <= 1'b0;
      alertSync <= '0;
    end else begin
      cmdDone   <= strobe.done;
      alertSync <= {alertSync[0], ~alertNIn};

      if (strobe.csLow) begin
        csN   <= 1'b0;
        io0Oe <= 1'b1;
      end else if (strobe.csHigh) begin
        csN   <= 1'b1;
        io0Oe <= 1'b0;
      end else if (strobe.oeOff) begin
        io0Oe <= 1'b0;
      end

      if (strobe.sckSet) begin
        sck <= 1'b1;
      end else if (strobe.sckClr) begin
        sck <= 1'b0;
      end

      if (strobe.loadTx) begin
        txShift <= cmdData;
        io0     <= cmdData[7];
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[6:0], 1'b0};
        io0     <= txShift[6];
      end

      if (strobe.sampleRx) begin
        rxShift <= {rxShift[6:0], io1In};
      end

      if (strobe.crcClear) begin
        crcAcc <= '0;
      end else if (strobe.finishRx) begin
        crcAcc <= crc8Fold(crcAcc, rxShift);
      end

      if (strobe.finishRx) begin
        rdData <= rxShift;
      end else if (strobe.crcRead) begin
        rdData <= crcAcc;
      end

      if (strobe.setRst) begin
        linkRstN <= cmdData[0];
      end
    end
  end

endmodule

// File: rtl/espi_shift_engine.sv
module espi_shift_engine
  import espi_eng_pkg::*;
#(
  parameter int CLK_DIV  = 5,
  parameter int SCK_HIGH = 2,
  parameter int TAR_W    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [7:0] cmdData,
  output logic       cmdReady,
  output logic       cmdDone,
  output logic [7:0] rdData,
  output logic       espiCsN,
  output logic       espiSck,
  output logic       espiIo0,
  output logic       espiIo0Oe,
  input  logic       espiIo1,
  output logic       espiRstN,
  input  logic       espiAlertN,
  output logic       alertSeen
);

  engStrobe_t strobe;

  espi_eng_ctrl #(
    .CLK_DIV (CLK_DIV),
    .SCK_HIGH(SCK_HIGH),
    .TAR_W   (TAR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdData (cmdData),
    .cmdReady(cmdReady),
    .strobe  (strobe)
  );

  espi_eng_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdData  (cmdData),
    .io1In    (espiIo1),
    .alertNIn (espiAlertN),
    .cmdDone  (cmdDone),
    .rdData   (rdData),
    .csN      (espiCsN),
    .sck      (espiSck),
    .io0      (espiIo0),
    .io0Oe    (espiIo0Oe),
    .linkRstN (espiRstN),
    .alertSeen(alertSeen)
  );

endmodule

// File: rtl/espi_shift_engine_chk.sv
module espi_shift_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic       cmdReady,
  input logic       cmdDone,
  input logic       espiCsN,
  input logic       espiSck,
  input logic       espiIo0,
  input logic       espiIo0Oe
);

  // R4: clock rests low while no command runs
  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !espiSck);

  // R3: outgoing bit holds while SCK stays high
  assert_io0_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (espiSck && $past(espiSck)) |-> $stable(espiIo0));

  // R2: enable never on outside a frame
  assert_oe_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    espiCsN |-> !espiIo0Oe);

  // R8: once released inside a frame, enable only returns through frame open
  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!espiIo0Oe && !espiCsN) |=>
      (!espiIo0Oe || $past(cmdValid && cmdReady && cmdOp == 3'd0)));

  // R9: completion is never signalled while the engine is still busy
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> cmdReady);

endmodule

bind espi_shift_engine espi_shift_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdReady (cmdReady),
  .cmdDone  (cmdDone),
  .espiCsN  (espiCsN),
  .espiSck  (espiSck),
  .espiIo0  (espiIo0),
  .espiIo0Oe(espiIo0Oe)
);

// File: tb/espi_shift_engine_test.sv
`timescale 1ns/1ps
module espi_shift_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 5;
  localparam int HI         = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [7:0] cmdData = '0;
  logic       cmdReady, cmdDone;
  logic [7:0] rdData;
  logic       espiCsN, espiSck, espiIo0, espiIo0Oe, espiRstN, alertSeen;
  logic       espiIo1;
  logic       espiAlertN = 1'b1;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  // target model: presents next response bit after each SCK fall
  logic [7:0] tgtByte = '0;
  int         tgtIdx = 0;
  assign espiIo1 = (tgtIdx < 8) ? tgtByte[7 - tgtIdx] : 1'b1;
  always @(negedge espiSck) tgtIdx++;

  // observer of the outgoing line and SCK timing
  logic [7:0] obsTx = '0;
  int   sckPulses = 0;
  time  firstRise = 0, lastRise = 0, highWidth = 0;
  always @(posedge espiSck) begin
    obsTx = {obsTx[6:0], espiIo0};
    if (sckPulses == 0) firstRise = $time;
    lastRise = $time;
    sckPulses++;
  end
  always @(negedge espiSck) highWidth = $time - lastRise;

  espi_shift_engine uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdReady(cmdReady), .cmdDone(cmdDone), .rdData(rdData),
    .espiCsN(espiCsN), .espiSck(espiSck), .espiIo0(espiIo0), .espiIo0Oe(espiIo0Oe),
    .espiIo1(espiIo1), .espiRstN(espiRstN), .espiAlertN(espiAlertN), .alertSeen(alertSeen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] refCrc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] v = c ^ b;
    for (int k = 0; k < 8; k++) v = {v[6:0], 1'b0} ^ (v[7] ? 8'h07 : 8'h00);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // issue one command and wait for its completion pulse
  task automatic runCmd(input logic [2:0] op, input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = d;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    forever begin
      @(negedge clk);
      if (cmdDone) break;
    end
    rd = rdData;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] crcModel;
    logic [7:0] pkt [3];
    void'($urandom(32'h00C0FFEE));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csN", espiCsN, 1);
    check("R1 sck", espiSck, 0);
    check("R1 oe", espiIo0Oe, 0);
    check("R1 rstPin", espiRstN, 0);
    check("R1 ready", cmdReady, 1);
    runCmd(3'd6, 8'h00, rd);
    check("R1 crc", rd, 8'h00);

    // R10 link reset pin
    runCmd(3'd7, 8'h01, rd);
    check("R10 rstPin high", espiRstN, 1);
    runCmd(3'd7, 8'hFE, rd);
    check("R10 rstPin low", espiRstN, 0);
    runCmd(3'd7, 8'h01, rd);

    // R2 frame open
    runCmd(3'd0, 8'h00, rd);
    check("R2 csN open", espiCsN, 0);
    check("R2 oe open", espiIo0Oe, 1);

    // R3/R4 random sends
    for (int n = 0; n < 12; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (n == 0) b = 8'h80;
      if (n == 1) b = 8'h01;
      sckPulses = 0;
      runCmd(3'd2, b, rd);
      check("R3 sent byte", obsTx, b);
      check("R3 pulses", sckPulses, 8);
      check("R4 high width", 32'(highWidth), HI * CLK_PERIOD);
      check("R4 period span", 32'(lastRise - firstRise), 7 * DIV * CLK_PERIOD);
      check("R4 idle low", espiSck, 0);
    end
    runCmd(3'd6, 8'h00, rd);
    check("R3 crc untouched by send", rd, 8'h00);

    // R8 turnaround lengths 0..3
    for (int t = 0; t < 4; t++) begin
      sckPulses = 0;
      runCmd(3'd4, 8'(t), rd);
      check("R8 tar pulses", sckPulses, t);
      check("R8 oe off", espiIo0Oe, 0);
    end

    // R5/R6 random receives against a model CRC
    runCmd(3'd5, 8'h00, rd);
    crcModel = 8'h00;
    for (int n = 0; n < 10; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      tgtByte = b; tgtIdx = 0;
      runCmd(3'd3, 8'h00, rd);
      check("R5 rx byte", rd, b);
      crcModel = refCrc(crcModel, b);
      runCmd(3'd6, 8'h00, rd);
      check("R6 crc", rd, crcModel);
      check("R8 oe stays off", espiIo0Oe, 0);
    end

    // R7 clear excludes earlier bytes; packet plus its CRC leaves zero
    runCmd(3'd5, 8'h00, rd);
    runCmd(3'd6, 8'h00, rd);
    check("R7 cleared", rd, 8'h00);
    pkt[0] = 8'h08; pkt[1] = 8'($urandom); pkt[2] = 8'($urandom);
    crcModel = 8'h00;
    for (int n = 0; n < 3; n++) begin
      tgtByte = pkt[n]; tgtIdx = 0;
      runCmd(3'd3, 8'h00, rd);
      crcModel = refCrc(crcModel, pkt[n]);
    end
    tgtByte = crcModel; tgtIdx = 0;
    runCmd(3'd3, 8'h00, rd);
    runCmd(3'd6, 8'h00, rd);
    check("R7 residue zero", rd, 8'h00);

    // R9 command while busy is ignored
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd2; cmdData = 8'hA5;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 busy", cmdReady, 0);
    cmdValid = 1'b1; cmdOp = 3'd1; cmdData = 8'h00;
    @(negedge clk);
    cmdValid = 1'b0;
    forever begin
      @(negedge clk);
      if (cmdDone) break;
    end
    check("R9 byte intact", obsTx, 8'hA5);
    check("R9 csN held", espiCsN, 0);

    // R2 frame close
    runCmd(3'd1, 8'h00, rd);
    check("R2 csN close", espiCsN, 1);
    check("R2 oe close", espiIo0Oe, 0);

    // R10 alert synchroniser
    @(negedge clk);
    espiAlertN = 1'b0;
    @(negedge clk);
    check("R10 alert delay", alertSeen, 0);
    @(negedge clk);
    check("R10 alert seen", alertSeen, 1);
    espiAlertN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 alert clear", alertSeen, 0);

    finishRun();
  end

endmodule